// File: doc/BRIEF.md
# Machine Software Interrupt Register Bank

This block is a memory-mapped bank of machine-level software-interrupt registers, one per hart. Other harts use it to send each other interrupts. Each hart owns one 32-bit word in a 16 KiB window. The word for hart `k` sits at byte offset `4*k`.

Bit 0 of each word is the only storage bit. Software writes 1 to raise that hart's pending line and writes 0 to lower it. The stored bit drives the hart's interrupt input as a level. All other bits read as zero and discard what is written to them.

The last word of the window is reserved. Slots past the configured hart count are also empty. Both read as zero and ignore writes.

The register interface is a simple single-cycle port:
- A write is accepted on the rising clock edge where `req_valid` and `req_write` are both high.
- Read data is combinational from the presented address.

Top module: `swirq_bank`

## Requirements
- R1: After reset, every `irq_pending` line is 0 and every slot reads back 0.
- R2: A write with bit 0 = 1 to byte offset `4*k`, for `k` < `NUM_HARTS`, drives `irq_pending[k]` high in the cycle after the write is accepted.
- R3: A write with bit 0 = 0 to byte offset `4*k` drives `irq_pending[k]` low in the cycle after the write is accepted.
- R4: A read of slot `k` returns `{31'b0, irq_pending[k]}`. Bits 31:1 of the written data are discarded and always read as 0.
- R5: A write to one slot leaves every other hart's pending line unchanged.
- R6: Reads of slot indices at or above `NUM_HARTS` return 0, and writes to them change no pending line. This includes the reserved word at offset 0x3FFC (slot 4095).
- R7: A pending line holds its level for as long as no write is accepted for its slot.
- R8: Address bits 1:0 do not take part in slot selection. Slot index = address bits 13:2.
- R9: When `req_valid` is low, no state changes and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte offset within the window |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_rdata | output | 32 | Combinational read data |
| irq_pending | output | NUM_HARTS | Per-hart machine software-interrupt level |

## Verification
The bench builds the bank with `NUM_HARTS = 5`. This is small enough that every live slot is hit many times. It also leaves slots 5 through 4094 and the reserved slot 4095 reachable as out-of-range targets.

Random writes carry random upper data bits and random address bits 1:0. This puts the discard rule of R4 and the selection rule of R8 under constant pressure. A five-bit reference model is compared against every pending line after every operation.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
  localparam int WIN_ADDR_W = 14;   // 16 KiB window
  localparam int SLOT_W     = 12;   // slot index width
  localparam int MAX_HARTS  = 4095; // slot 4095 is reserved

  // Slot index from a byte offset; bits 1:0 are ignored.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [WIN_ADDR_W-1:0] a);
    return a[WIN_ADDR_W-1:2];
  endfunction

  // A slot is live when it is below the configured hart count.
  function automatic logic slot_live(input logic [SLOT_W-1:0] s, input int unsigned n);
    return ({20'd0, s} < n);
  endfunction
endpackage

// File: rtl/swirq_decode.sv
module swirq_decode
  import swirq_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                  req_valid,
  input  logic [WIN_ADDR_W-1:0] req_addr,
  output logic [NUM_HARTS-1:0]  slot_sel,
  output logic                  slot_hit
);
  logic [SLOT_W-1:0] idx;
  assign idx = slot_of(req_addr);

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_sel
    assign slot_sel[i] = req_valid && (idx == SLOT_W'(i));
  end

  assign slot_hit = req_valid && slot_live(idx, NUM_HARTS);
endmodule

// File: rtl/swirq_cell.sv
module swirq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= 1'b0;
    else if (wr_en) pend <= wr_bit;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit) |=> pend);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit) |=> !pend);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend));
endmodule

// File: rtl/swirq_readback.sv
module swirq_readback #(
  parameter int NUM_HARTS = 4
) (
  input  logic                 rd_en,
  input  logic [NUM_HARTS-1:0] slot_sel,
  input  logic [NUM_HARTS-1:0] pend_vec,
  output logic [31:0]          rdata
);
  logic bit0;
  assign bit0  = rd_en && (|(slot_sel & pend_vec));
  assign rdata = {31'd0, bit0};
endmodule

// File: rtl/swirq_bank.sv
module swirq_bank
  import swirq_pkg::*;
#(
  parameter int NUM_HARTS = 4  // 1 .. MAX_HARTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [WIN_ADDR_W-1:0] req_addr,
  input  logic [31:0]           req_wdata,
  output logic [31:0]           rsp_rdata,
  output logic [NUM_HARTS-1:0]  irq_pending
);
  logic [NUM_HARTS-1:0] slot_sel;
  logic                 slot_hit;
  logic                 wr_req;
  logic                 rd_req;
  logic [NUM_HARTS-1:0] wr_vec;

  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  swirq_decode #(.NUM_HARTS(NUM_HARTS)) decode_i (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .slot_sel  (slot_sel),
    .slot_hit  (slot_hit)
  );

  assign wr_vec = slot_sel & {NUM_HARTS{wr_req}};

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_cell
    swirq_cell cell_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_vec[i]),
      .wr_bit (req_wdata[0]),
      .pend   (irq_pending[i])
    );
  end

  swirq_readback #(.NUM_HARTS(NUM_HARTS)) readback_i (
    .rd_en    (rd_req),
    .slot_sel (slot_sel),
    .pend_vec (irq_pending),
    .rdata    (rsp_rdata)
  );

  assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  assert_hit_matches_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_hit == (|slot_sel));
  assert_oob_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !slot_hit) |=> $stable(irq_pending));
  assert_oob_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !slot_hit) |-> (rsp_rdata == 32'd0));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(irq_pending));
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[31:1] == 31'd0);
endmodule

// File: tb/swirq_bank_tb.sv
module swirq_bank_tb_top;
  localparam int NH = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [13:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rsp_rdata;
  logic [NH-1:0] irq_pending;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [NH-1:0] model = '0;

  always #10 clk = ~clk; // 50 MHz

  swirq_bank #(.NUM_HARTS(NH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_pending(irq_pending)
  );

  function automatic int slot_num(input logic [13:0] a);
    return int'(a) / 4;
  endfunction

  function automatic logic [31:0] expect_read(input logic [13:0] a, input logic [NH-1:0] m);
    int s = slot_num(a);
    if (s >= NH) return 32'd0;
    return {31'd0, m[s]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    if (slot_num(a) < NH) model[slot_num(a)] = d[0];
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(req, 32'(irq_pending), 32'(model));
  endtask

  task automatic rd(input logic [13:0] a, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 check(req, rsp_rdata, expect_read(a, model));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset lines", 32'(irq_pending), 32'd0);
    for (int k = 0; k < NH; k++) rd(14'(4*k), "R1 reset read");

    wr(14'h0008, 32'h0000_0001, "R2 set slot 2");
    rd(14'h0008, "R4 read slot 2");
    wr(14'h0008, 32'hFFFF_FFFE, "R3 clear via upper-bit data");
    rd(14'h0008, "R4 upper bits discarded");
    wr(14'h0010, 32'hFFFF_FFFF, "R2 set last live slot");
    rd(14'h0013, "R8 low addr bits ignored on read");
    wr(14'h0003, 32'h1, "R8 low addr bits ignored on write");
    wr(14'h0001, 32'h0, "R5 clear slot 0 others kept");
    wr(14'h0014, 32'h1, "R6 first empty slot write");
    rd(14'h0014, "R6 first empty slot read");
    wr(14'h3FFC, 32'h1, "R6 reserved write");
    rd(14'h3FFC, "R6 reserved read");

    // R9: idle cycles change nothing and read zero.
    repeat (4) @(negedge clk);
    req_addr = 14'h0010;
    #1 check("R9 idle rdata", rsp_rdata, 32'd0);
    check("R7 level held while idle", 32'(irq_pending), 32'(model));

    for (int n = 0; n < 400; n++) begin
      logic [13:0] a;
      int pick = $urandom_range(0, 9);
      if (pick < 7)      a = 14'(4 * $urandom_range(0, NH - 1) + $urandom_range(0, 3));
      else if (pick < 9) a = 14'($urandom_range(4 * NH, 16383));
      else               a = 14'h3FFC + 14'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) wr(a, $urandom, "R2/R3/R5/R6 random write");
      else                          rd(a, "R4/R6 random read");
    end
    finish_run();
  end
endmodule